// File: doc/BRIEF.md
# Interrupt Nesting Bus-Takeover Guard

This block watches a CPU bus and tells expansion hardware when a bus takeover would be unsafe. A falling edge on the active-low vector-pull signal means an interrupt has started. Each opcode fetch is checked, and a fetch of the return-from-interrupt opcode means that interrupt has ended. A saturating depth counter follows nested interrupts. The guard output is high whenever the depth is nonzero.

The opcode check runs once per bus cycle. It samples the SYNC line and the data bus at the end of the PHI2 high phase. This is the first block clock edge at which PHI2 reads low after reading high. The block also gives a permit output. Its purpose is to let a bus master start a takeover on an opcode fetch that happens outside any interrupt. All inputs are taken to be synchronous to the block clock.

Top module: `ivp_inhibit`

## Requirements
- R1: A 1-to-0 transition of `vpb_n` adds one to the nesting depth. Holding `vpb_n` low for any number of cycles adds only one. `inhibit` is high exactly when the depth is nonzero.
- R2: The depth drops by one when, at the first clock edge where `phi2` reads low after reading high, `sync` is 1 and `data` equals 8'h40.
- R3: The depth does not change in any of these cases: `sync` is 0 at that edge, `data` is not 8'h40, or `phi2` shows no falling transition.
- R4: The depth saturates at 2**DEPTH_W-1 (15 by default). Further vector pulls leave it there.
- R5: A return opcode seen at depth zero is ignored, and the depth stays zero.
- R6: `grant_ok` equals `sync` while the depth is zero and is 0 while `inhibit` is high.
- R7: An active-low `rst_n` clears the depth to zero, so `inhibit` reads 0 after reset.
- R8: A vector-pull edge and a return-opcode match on the same clock edge cancel, and the depth is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vpb_n | input | 1 | Active-low vector-pull indicator from the CPU |
| sync | input | 1 | High during an opcode fetch cycle |
| phi2 | input | 1 | CPU phase-2 clock, sampled as data |
| data | input | DATA_W (8) | CPU data bus |
| inhibit | output | 1 | High while an interrupt is in progress |
| grant_ok | output | 1 | High on an opcode fetch outside any interrupt |

## Verification
The only internal state is the depth count, and it shows up at the ports solely through `inhibit` and `grant_ok`. A count that is wrong but still nonzero stays hidden until enough return opcodes have been fetched to unwind it. The bench therefore unwinds every nesting level it builds, which exposes an off-by-one on the fetch where the guard should drop, or one fetch too early. A saturation fault appears as the guard falling one return opcode too soon. A missed edge on either strobe appears on the first bus cycle after it.

// File: rtl/ivp_pkg.sv
package ivp_pkg;
   localparam logic [7:0] RTI_OPCODE = 8'h40;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;
endpackage

// File: rtl/ivp_edge.sv
// Single-cycle pulse on a chosen transition of a level input.
module ivp_edge #(
   parameter bit RISING     = 1'b0,
   parameter bit IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic pulse
);
   logic din_q;

   always_ff @(posedge clk) begin
      if (!rst_n) din_q <= IDLE_LEVEL;
      else        din_q <= din;
   end

   generate
      if (RISING) begin : g_rise
         assign pulse = din & ~din_q;
      end else begin : g_fall
         assign pulse = ~din & din_q;
      end
   endgenerate
endmodule

// File: rtl/ivp_opmatch.sv
// Flags a fetched opcode equal to OPCODE on a sampling strobe.
module ivp_opmatch #(
   parameter int              DATA_W = 8,
   parameter logic [DATA_W-1:0] OPCODE = '0
) (
   input  logic              strobe,
   input  logic              sync,
   input  logic [DATA_W-1:0] data,
   output logic              hit
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("ivp_opmatch: DATA_W must be at least 1");
      end
   endgenerate

   assign hit = strobe & sync & (data == OPCODE);
endmodule

// File: rtl/ivp_depth.sv
// Saturating up/down nesting counter.
module ivp_depth
   import ivp_pkg::*;
#(
   parameter int DEPTH_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               up,
   input  logic               down,
   output logic [DEPTH_W-1:0] count
);
   localparam logic [DEPTH_W-1:0] CNT_MAX  = '1;
   localparam logic [DEPTH_W-1:0] CNT_ZERO = '0;
   localparam logic [DEPTH_W-1:0] CNT_ONE  = DEPTH_W'(1);

   generate
      if (DEPTH_W < 2) begin : g_bad_depth
         $error("ivp_depth: DEPTH_W must be at least 2");
      end
   endgenerate

   step_e step;

   always_comb begin
      step = STEP_HOLD;
      if (up && !down && count != CNT_MAX)         step = STEP_UP;
      else if (down && !up && count != CNT_ZERO)   step = STEP_DOWN;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) count <= CNT_ZERO;
      else begin
         case (step)
            STEP_UP:   count <= count + CNT_ONE;
            STEP_DOWN: count <= count - CNT_ONE;
            default:   count <= count;
         endcase
      end
   end

   // R3: no strobe leaves the depth alone
   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!up && !down) |=> $stable(count));
   // R4: saturation at the top
   p_sat_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !down && count == CNT_MAX) |=> (count == CNT_MAX));
   // R5: saturation at zero
   p_sat_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (down && !up && count == CNT_ZERO) |=> (count == CNT_ZERO));
   // R8: coincident strobes cancel
   p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (up && down) |=> $stable(count));
endmodule

// File: rtl/ivp_inhibit.sv
// Interrupt-nesting guard: vector-pull edges nest, return-opcode fetches unwind.
module ivp_inhibit
   import ivp_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int DEPTH_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vpb_n,
   input  logic              sync,
   input  logic              phi2,
   input  logic [DATA_W-1:0] data,
   output logic              inhibit,
   output logic              grant_ok
);
   localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);

   generate
      if (DATA_W < 8) begin : g_bad_bus
         $error("ivp_inhibit: DATA_W must hold the return opcode");
      end
   endgenerate

   logic               pull_start;
   logic               phase_end;
   logic               rti_hit;
   logic [DEPTH_W-1:0] depth;

   // vector pull begins on the falling edge of the active-low indicator
   ivp_edge #(.RISING(1'b0), .IDLE_LEVEL(1'b1)) u_pull_edge (
      .clk(clk), .rst_n(rst_n), .din(vpb_n), .pulse(pull_start));

   // end of PHI2 high phase: sampling point for the fetched opcode
   ivp_edge #(.RISING(1'b0), .IDLE_LEVEL(1'b0)) u_phase_edge (
      .clk(clk), .rst_n(rst_n), .din(phi2), .pulse(phase_end));

   ivp_opmatch #(.DATA_W(DATA_W), .OPCODE(DATA_W'(RTI_OPCODE))) u_match (
      .strobe(phase_end), .sync(sync), .data(data), .hit(rti_hit));

   ivp_depth #(.DEPTH_W(DEPTH_W)) u_depth (
      .clk(clk), .rst_n(rst_n), .up(pull_start), .down(rti_hit), .count(depth));

   assign inhibit  = |depth;
   assign grant_ok = sync & ~inhibit;

   // R1: a lone pull edge always leaves the guard raised
   p_set_on_pull_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_start && !rti_hit) |=> inhibit);
   // R2: return opcode at depth one drops the guard
   p_clear_on_rti_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rti_hit && !pull_start && depth == DEPTH_ONE) |=> !inhibit);
   // R1: a held-low pull indicator raises no second edge
   p_single_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!vpb_n && $past(!vpb_n)) |-> !pull_start);
endmodule

// File: tb/sim_ivp_inhibit.sv
module sim_ivp_inhibit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vpb_n = 1'b1;
   logic       sync = 1'b0;
   logic       phi2 = 1'b0;
   logic [7:0] data = 8'h00;
   logic       inhibit;
   logic       grant_ok;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;   // 250 MHz

   ivp_inhibit u0 (
      .clk(clk), .rst_n(rst_n), .vpb_n(vpb_n), .sync(sync), .phi2(phi2),
      .data(data), .inhibit(inhibit), .grant_ok(grant_ok));

   // op kinds: 0 plain fetch, 1 vector pull, 2 return fetch, 3 non-fetch with 8'h40
   localparam int NOPS = 9;
   localparam logic [1:0] OP_KIND [NOPS] = '{2'd2, 2'd1, 2'd3, 2'd0, 2'd1, 2'd2, 2'd2, 2'd1, 2'd2};
   localparam logic       OP_INH  [NOPS] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
   localparam string      OP_REQ  [NOPS] = '{"R5", "R1", "R3", "R3", "R1", "R2", "R2", "R1", "R2"};

   task automatic check(input logic actual, input logic expected, input string req);
      checks++;
      if (actual !== expected) begin
         failures++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", req, actual, expected, $time);
      end
   endtask

   task automatic bus_cycle(input logic s, input logic [7:0] d, input logic v);
      @(negedge clk); sync = s; data = d; vpb_n = v; phi2 = 1'b1;
      @(negedge clk);
      @(negedge clk); phi2 = 1'b0;
      @(negedge clk);
   endtask

   task automatic vector_pull();
      bus_cycle(1'b0, 8'hFF, 1'b0);
      bus_cycle(1'b0, 8'hFF, 1'b0);
      bus_cycle(1'b0, 8'h00, 1'b1);
   endtask

   task automatic grant_probe(input logic expected, input string req);
      @(negedge clk); sync = 1'b1; data = 8'hEA; phi2 = 1'b1; vpb_n = 1'b1;
      @(negedge clk);
      check(grant_ok, expected, req);
      sync = 1'b0;
   endtask

   initial begin
      #800000;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(inhibit, 1'b0, "R7 reset state");
      grant_probe(1'b1, "R6 idle fetch grant");

      for (int i = 0; i < NOPS; i++) begin
         case (OP_KIND[i])
            2'd0: bus_cycle(1'b1, 8'hEA, 1'b1);
            2'd1: vector_pull();
            2'd2: bus_cycle(1'b1, 8'h40, 1'b1);
            default: bus_cycle(1'b0, 8'h40, 1'b1);
         endcase
         check(inhibit, OP_INH[i], OP_REQ[i]);
      end

      // R1: long low pull counts once; one return clears it
      bus_cycle(1'b0, 8'hFF, 1'b0);
      repeat (6) bus_cycle(1'b0, 8'hFF, 1'b0);
      grant_probe(1'b0, "R6 no grant while inhibited");
      bus_cycle(1'b1, 8'h40, 1'b1);
      check(inhibit, 1'b0, "R1 long pull counted once");

      // R3: return opcode with no PHI2 falling edge is ignored
      vector_pull();
      @(negedge clk); sync = 1'b1; data = 8'h40; phi2 = 1'b1;
      repeat (6) @(negedge clk);
      check(inhibit, 1'b1, "R3 no phase end no match");
      bus_cycle(1'b1, 8'h40, 1'b1);
      check(inhibit, 1'b0, "R2 unwind after held phase");

      // R4: saturation at 15
      for (int i = 0; i < 16; i++) vector_pull();
      check(inhibit, 1'b1, "R4 sixteen pulls");
      for (int i = 0; i < 14; i++) bus_cycle(1'b1, 8'h40, 1'b1);
      check(inhibit, 1'b1, "R4 fourteen returns");
      bus_cycle(1'b1, 8'h40, 1'b1);
      check(inhibit, 1'b0, "R4 fifteenth return clears");
      grant_probe(1'b1, "R6 grant after unwind");

      // R8: coincident pull edge and return match
      vector_pull();
      @(negedge clk); sync = 1'b1; data = 8'h40; vpb_n = 1'b1; phi2 = 1'b1;
      @(negedge clk);
      @(negedge clk); vpb_n = 1'b0; phi2 = 1'b0;
      @(negedge clk);
      check(inhibit, 1'b1, "R8 coincident keeps depth");
      bus_cycle(1'b0, 8'h00, 1'b1);
      bus_cycle(1'b1, 8'h40, 1'b1);
      check(inhibit, 1'b0, "R8 depth was one");

      // R7: reset mid-nesting
      vector_pull();
      vector_pull();
      vector_pull();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(inhibit, 1'b0, "R7 reset clears depth");
      grant_probe(1'b1, "R7 grant after reset");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule